// File: doc/BRIEF.md
# Banked GPIO Controller with Half-Word Masked Writes

This controller drives and samples a set of general-purpose pins grouped into four banks. Each bank keeps three registers: output levels, pin direction and output enable. It also has a read-only view of the live input levels. Software reaches all of them over a plain 32-bit register bus: address, write strobe, write data, and a combinational read data return.

To change single pins without a read-modify-write, each bank also has two write-only masked ports. One covers pins 0 to 15 and the other covers pins 16 to 31. Each write carries a 16-bit protect mask in the upper half-word and 16 new levels in the lower half-word.

The banks are not all the same width. Bank 1 has only 22 pins, and two pins of bank 0 are wired so that they can never become inputs.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every output level bit is 0 and every output-enable bit is 0. Every direction bit is 0, except bank 0 bits 7 and 8, which are 1. No pin is driven.
- R2: A write to offset 0x000 + 8*N updates pins 0..15 of bank N. For each bit, a mask bit (write data bit 16+k) of 0 loads data bit k, and a mask bit of 1 keeps the old level. The new value is visible from the cycle after the write.
- R3: A write to offset 0x004 + 8*N applies the same masked update to pins 16..31 of bank N, with pin p taken from data bit p-16.
- R4: A masked write whose mask bits 31:16 are all ones leaves every output level unchanged.
- R5: A read at 0x060 + 4*N returns the live input levels of bank N, with bit k holding pin k.
- R6: A pin is driven (pin_oe bit set) only when both its direction bit (1 = output) and its output-enable bit are 1. Direction is read and written at 0x200 + 0x40*N, and output enable at 0x204 + 0x40*N.
- R7: Bank 0 direction bits 7 and 8 always read as 1. A write of 0 to them has no effect.
- R8: Banks 0, 2 and 3 have 32 pins and bank 1 has 22. Bits of unimplemented pins read as 0 and are never driven or set.
- R9: The output level register of bank N is written in full and read back at 0x040 + 4*N.
- R10: The masked-write offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 128 | Live pin levels, 32 bits per bank |
| pin_out | output | 128 | Output levels, 32 bits per bank |
| pin_oe | output | 128 | Per-pin drive enable, 32 bits per bank |

## Verification
A wrong merge between mask and data shows up on pin_out one cycle after the offending masked write. It also shows up on an immediate readback of the level register.

A corrupted direction or enable bit shows on pin_oe in the cycle after the write. A lost forced direction bit shows in the same way.

Width errors in the narrow bank show as stray ones above bit 21. They appear in the read value and on the pins, right after any write that tries to set those bits.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int BANKS       = 4,
  parameter int NARROW_BANK = 1,
  parameter int NARROW_PINS = 22,
  parameter int ADDR_W      = 12,
  localparam int PINS       = 32 * BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);

  function automatic logic [31:0] width_mask(int b);
    return (b == NARROW_BANK) ? 32'((64'd1 << NARROW_PINS) - 64'd1) : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] forced_dir(int b);
    return (b == 0) ? 32'h0000_0180 : 32'h0;
  endfunction

  function automatic logic [ADDR_W-1:0] at(int base, int stride, int b);
    return ADDR_W'(base + stride * b);
  endfunction

  function automatic logic [15:0] merge(logic [15:0] old, logic [31:0] w);
    return (old & w[31:16]) | (w[15:0] & ~w[31:16]);
  endfunction

  logic [31:0] lvl [BANKS];
  logic [31:0] dir [BANKS];
  logic [31:0] oen [BANKS];
  logic        mport_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++) begin
        lvl[b] <= '0;
        dir[b] <= forced_dir(b);
        oen[b] <= '0;
      end
    end else if (bus_wr) begin
      for (int b = 0; b < BANKS; b++) begin
        if (bus_addr == at(0, 8, b))
          lvl[b] <= {lvl[b][31:16], merge(lvl[b][15:0], bus_wdata)} & width_mask(b);
        if (bus_addr == at(4, 8, b))
          lvl[b] <= {merge(lvl[b][31:16], bus_wdata), lvl[b][15:0]} & width_mask(b);
        if (bus_addr == at('h40, 4, b))
          lvl[b] <= bus_wdata & width_mask(b);
        if (bus_addr == at('h200, 'h40, b))
          dir[b] <= (bus_wdata | forced_dir(b)) & width_mask(b);
        if (bus_addr == at('h204, 'h40, b))
          oen[b] <= bus_wdata & width_mask(b);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    mport_hit = 1'b0;
    for (int b = 0; b < BANKS; b++) begin
      if (bus_addr == at(0, 8, b) || bus_addr == at(4, 8, b)) mport_hit = 1'b1;
      if (bus_addr == at('h40, 4, b))    bus_rdata = lvl[b];
      if (bus_addr == at('h60, 4, b))    bus_rdata = pin_in[32*b +: 32] & width_mask(b);
      if (bus_addr == at('h200, 'h40, b)) bus_rdata = dir[b];
      if (bus_addr == at('h204, 'h40, b)) bus_rdata = oen[b];
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign pin_out[32*b +: 32] = lvl[b];
    assign pin_oe[32*b +: 32]  = dir[b] & oen[b];
  end

  AST_FULL_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && mport_hit && bus_wdata[31:16] == 16'hFFFF) |=> $stable(pin_out)); // R4
  AST_IDLE_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pin_out) && $stable(pin_oe))); // R2
  AST_NARROW_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out[32*NARROW_BANK+NARROW_PINS +: 32-NARROW_PINS] == '0 &&
     pin_oe[32*NARROW_BANK+NARROW_PINS +: 32-NARROW_PINS] == '0)); // R8
  AST_FORCED_DIR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h200)) |-> (bus_rdata[8:7] == 2'b11)); // R7
  AST_MPORT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mport_hit |-> (bus_rdata == 32'h0)); // R10

endmodule

// File: tb/test_gpio_bank_ctrl.sv
module test_gpio_bank_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, pin_oe;
  int checks = 0, errors = 0;

  gpio_bank_ctrl i_gpio_bank_ctrl (.*);

  always #10 clk = ~clk;

  // {write addr, write data, read addr, expected, requirement number}
  localparam int NV = 12;
  localparam logic [91:0] VEC [NV] = '{
    {12'h000, 32'h0000_A5A5, 12'h040, 32'h0000_A5A5, 4'd2},  // R2
    {12'h000, 32'hFF00_00FF, 12'h040, 32'h0000_A5FF, 4'd2},  // R2
    {12'h004, 32'h0000_1234, 12'h040, 32'h1234_A5FF, 4'd3},  // R3
    {12'h004, 32'hFFFF_0000, 12'h040, 32'h1234_A5FF, 4'd4},  // R4
    {12'h00C, 32'h0000_FFFF, 12'h044, 32'h003F_0000, 4'd8},  // R8
    {12'h044, 32'hFFFF_FFFF, 12'h044, 32'h003F_FFFF, 4'd8},  // R8
    {12'h018, 32'h0000_8001, 12'h04C, 32'h0000_8001, 4'd2},  // R2
    {12'h048, 32'hDEAD_BEEF, 12'h048, 32'hDEAD_BEEF, 4'd9},  // R9
    {12'h014, 32'h0F0F_0000, 12'h048, 32'h0E0D_BEEF, 4'd3},  // R3
    {12'h200, 32'h0000_0000, 12'h200, 32'h0000_0180, 4'd7},  // R7
    {12'h204, 32'h0000_FFFF, 12'h204, 32'h0000_FFFF, 4'd6},  // R6
    {12'h000, 32'h0000_0000, 12'h000, 32'h0000_0000, 4'd10}  // R10
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, string req, logic [31:0] exp);
    bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(12'h040, "R1", 32'h0);
    rd(12'h200, "R1", 32'h0000_0180);
    rd(12'h204, "R1", 32'h0);
    check("R1", pin_out[31:0] | pin_out[127:96], 32'h0);
    check("R1", pin_oe[31:0] | pin_oe[63:32], 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][91:80], VEC[i][79:48]);
      rd(VEC[i][47:36], $sformatf("R%0d", VEC[i][3:0]), VEC[i][35:4]);
    end

    // R8 narrow bank pins and R3 pin mapping of bank 2
    check("R8", pin_out[63:32], 32'h003F_FFFF);
    check("R3", pin_out[95:64], 32'h0E0D_BEEF);
    // R6 drive only where direction and enable agree
    check("R6", pin_oe[31:0], 32'h0000_0180);
    wr(12'h200, 32'h0000_000F);
    check("R6", pin_oe[31:0], 32'h0000_018F);
    wr(12'h204, 32'h0000_0100);
    check("R6", pin_oe[31:0], 32'h0000_0100);
    // R5 live input sampling
    pin_in = {32'h1357_9BDF, 32'hCAFE_F00D, 32'hFFFF_FFFF, 32'h8765_4321};
    rd(12'h060, "R5", 32'h8765_4321);
    rd(12'h064, "R8", 32'h003F_FFFF);
    rd(12'h068, "R5", 32'hCAFE_F00D);
    rd(12'h06C, "R5", 32'h1357_9BDF);
    // R4 full mask on the lower port leaves bank 3 alone
    wr(12'h018, 32'hFFFF_0000);
    check("R4", pin_out[127:96], 32'h0000_8001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule